// File: doc/BRIEF.md
# Profiling Exception Enable Resolver

This block decides how buffer management events from a statistical profiling unit are handled at the hypervisor level. It takes the two-bit exception-enable mode that the hypervisor programmed and resolves it against the configuration of the levels above it: the firmware-level enable mode, whether a hypervisor exists, and the security-state pair. The result is the effective mode. It is one of four named states: OFF (00), DELEGATED (01), TARGETED (10) and TRAP_ALL (11).

From the effective mode the block derives three things. The first is whether the current buffer management event is recorded in the hypervisor-level status, which depends on the event's fault class, the buffer owning level and two routing bits. The second is whether the hypervisor-level service bit raises an exception request, taking the kernel mask into account. The third is whether the interrupt line follows the lower-level service bit.

The resolution is a fixed priority chain. Its three transitions are L3_OFF → OFF, NO_HYP → DELEGATED and PASS → programmed mode. A parameter selects between a purely combinational path and one pipeline register on every output.

Top module: `pxr_resolver`

## Requirements
- R1: When `l3_mode` is 00, `eff_mode` is 00 (OFF), whatever the other configuration inputs are.
- R2: When `l3_mode` is not 00 and either `hyp_present` is 0 or {`sec_ns`,`sec_l2en`} is {0,0}, `eff_mode` is 01 (DELEGATED).
- R3: In every other case `eff_mode` equals `cfg_mode`.
- R4: In effective modes 00 and 01, `rec_l2` is 0 for every event.
- R5: Event classes are encoded on `evt_class` as 0 management (non-fault), 1 first-stage fault, 2 second-stage fault, 3 external abort, 4 protection-table fault, 5 other protection-check fault, and 6 and 7 treated as management. In effective mode 10 with `owner_l2`=1, classes 1 to 5 are recorded. With `owner_l2`=0, classes 2 and 5 are always recorded, class 3 only when `abort_route`=1, class 4 only when `prot_route`=1, and class 1 never. Management classes are never recorded in this mode.
- R6: In effective mode 11, every valid event of any class is recorded.
- R7: `rec_l2` is 0 whenever `evt_valid` is 0 or `l3_divert` is 1, in every mode.
- R8: An exception is unmasked only when `kern_en`=1 and `pm_bit`=0. With `kern_en`=0, `exc_req` is always 0.
- R9: `exc_req` equals `svc_l2` AND unmasked in modes 10 and 11. In mode 01 it also requires `gen_trap`=1. In mode 00 it is 0.
- R10: `irq_l1` follows `svc_l1` in effective mode 00 and is 0 in all other modes.
- R11: With `PIPE`=1 (default) every output is registered: it is 0 while `rst_n` is low and shows the result of the inputs one clock edge later. With `PIPE`=0 the outputs are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional pipeline register |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | Mode programmed at the hypervisor level |
| l3_mode | input | 2 | Firmware-level enable mode; 00 forces OFF |
| l3_divert | input | 1 | Firmware routing sends recording to its own status |
| hyp_present | input | 1 | Hypervisor level implemented |
| sec_ns | input | 1 | Security pair, first bit |
| sec_l2en | input | 1 | Security pair, second bit |
| owner_l2 | input | 1 | Profiling buffer owned by the hypervisor level |
| evt_valid | input | 1 | A buffer management event is present |
| evt_class | input | 3 | Event fault class (encoding in R5) |
| abort_route | input | 1 | External aborts routed to the hypervisor |
| prot_route | input | 1 | Protection-table faults routed to the hypervisor |
| gen_trap | input | 1 | Effective trap-general-exceptions control |
| svc_l2 | input | 1 | Hypervisor-level status service bit |
| svc_l1 | input | 1 | Lower-level status service bit |
| kern_en | input | 1 | Kernel exception enable |
| pm_bit | input | 1 | Processor profiling mask bit |
| eff_mode | output | 2 | Effective exception-enable mode |
| rec_l2 | output | 1 | Record event in hypervisor-level status |
| exc_req | output | 1 | Exception request to the hypervisor level |
| irq_l1 | output | 1 | Interrupt line driven from the lower-level service bit |

## Verification
A wrong step in the priority chain shows at once on `eff_mode`, one edge after the inputs in the pipelined variant. It then spreads to all three flags, so a misordered override breaks record, exception and interrupt checks together. A wrong class decode or routing bit leaves `eff_mode` correct and flips only `rec_l2`, and only for the one owner and class combination affected. The sweeps therefore cover every class under both owners and both routing settings.

// File: rtl/pxr_pkg.sv
package pxr_pkg;
    parameter int MODE_W  = 2;
    parameter int CLASS_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MD_OFF    = 2'b00,
        MD_DELEG  = 2'b01,
        MD_TARGET = 2'b10,
        MD_ALL    = 2'b11
    } mode_e;

    typedef enum logic [CLASS_W-1:0] {
        EV_MGMT  = 3'd0,
        EV_S1    = 3'd1,
        EV_S2    = 3'd2,
        EV_EXTAB = 3'd3,
        EV_PTAB  = 3'd4,
        EV_PCHK  = 3'd5,
        EV_RSV6  = 3'd6,
        EV_RSV7  = 3'd7
    } evt_e;

    typedef struct packed {
        mode_e mode;
        logic  rec;
        logic  exc;
        logic  irq;
    } res_t;
endpackage

// File: rtl/pxr_mode_resolve.sv
module pxr_mode_resolve
    import pxr_pkg::*;
(
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic [MODE_W-1:0] l3_mode,
    input  logic              hyp_present,
    input  logic              sec_ns,
    input  logic              sec_l2en,
    output mode_e             eff
);
    logic no_hyp;

    always_comb begin
        no_hyp = !hyp_present || ({sec_ns, sec_l2en} == 2'b00);
        if (mode_e'(l3_mode) == MD_OFF) begin
            eff = MD_OFF;                 // transition L3_OFF
        end else if (no_hyp) begin
            eff = MD_DELEG;               // transition NO_HYP
        end else begin
            eff = mode_e'(cfg_mode);      // transition PASS
        end
    end
endmodule

// File: rtl/pxr_rec_filter.sv
module pxr_rec_filter
    import pxr_pkg::*;
(
    input  mode_e              mode,
    input  logic               owner_l2,
    input  logic               evt_valid,
    input  logic [CLASS_W-1:0] evt_class,
    input  logic               abort_route,
    input  logic               prot_route,
    input  logic               l3_divert,
    output logic               rec
);
    logic target_hit;
    logic sel;

    always_comb begin
        unique case (evt_e'(evt_class))
            EV_S1:            target_hit = owner_l2;
            EV_S2, EV_PCHK:   target_hit = 1'b1;
            EV_EXTAB:         target_hit = owner_l2 | abort_route;
            EV_PTAB:          target_hit = owner_l2 | prot_route;
            default:          target_hit = 1'b0;
        endcase
    end

    always_comb begin
        unique case (mode)
            MD_OFF, MD_DELEG: sel = 1'b0;
            MD_TARGET:        sel = target_hit;
            MD_ALL:           sel = 1'b1;
            default:          sel = 1'b0;
        endcase
        rec = evt_valid & sel & ~l3_divert;
    end
endmodule

// File: rtl/pxr_exc_gate.sv
module pxr_exc_gate
    import pxr_pkg::*;
(
    input  mode_e mode,
    input  logic  gen_trap,
    input  logic  svc_l2,
    input  logic  svc_l1,
    input  logic  kern_en,
    input  logic  pm_bit,
    output logic  exc,
    output logic  irq
);
    logic unmasked;
    logic route;

    always_comb begin
        unmasked = kern_en & ~pm_bit;
        unique case (mode)
            MD_OFF: begin
                route = 1'b0;
                irq   = svc_l1;
            end
            MD_DELEG: begin
                route = gen_trap;
                irq   = 1'b0;
            end
            MD_TARGET, MD_ALL: begin
                route = 1'b1;
                irq   = 1'b0;
            end
            default: begin
                route = 1'b0;
                irq   = 1'b0;
            end
        endcase
        exc = route & svc_l2 & unmasked;
    end
endmodule

// File: rtl/pxr_resolver.sv
module pxr_resolver
    import pxr_pkg::*;
#(
    parameter bit PIPE = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MODE_W-1:0]  cfg_mode,
    input  logic [MODE_W-1:0]  l3_mode,
    input  logic               l3_divert,
    input  logic               hyp_present,
    input  logic               sec_ns,
    input  logic               sec_l2en,
    input  logic               owner_l2,
    input  logic               evt_valid,
    input  logic [CLASS_W-1:0] evt_class,
    input  logic               abort_route,
    input  logic               prot_route,
    input  logic               gen_trap,
    input  logic               svc_l2,
    input  logic               svc_l1,
    input  logic               kern_en,
    input  logic               pm_bit,
    output logic [MODE_W-1:0]  eff_mode,
    output logic               rec_l2,
    output logic               exc_req,
    output logic               irq_l1
);
    mode_e eff_d;
    logic  rec_d;
    logic  exc_d;
    logic  irq_d;
    res_t  res_d;
    res_t  res_q;

    pxr_mode_resolve u_mode (
        .cfg_mode    (cfg_mode),
        .l3_mode     (l3_mode),
        .hyp_present (hyp_present),
        .sec_ns      (sec_ns),
        .sec_l2en    (sec_l2en),
        .eff         (eff_d)
    );

    pxr_rec_filter u_rec (
        .mode        (eff_d),
        .owner_l2    (owner_l2),
        .evt_valid   (evt_valid),
        .evt_class   (evt_class),
        .abort_route (abort_route),
        .prot_route  (prot_route),
        .l3_divert   (l3_divert),
        .rec         (rec_d)
    );

    pxr_exc_gate u_exc (
        .mode     (eff_d),
        .gen_trap (gen_trap),
        .svc_l2   (svc_l2),
        .svc_l1   (svc_l1),
        .kern_en  (kern_en),
        .pm_bit   (pm_bit),
        .exc      (exc_d),
        .irq      (irq_d)
    );

    always_comb begin
        res_d.mode = eff_d;
        res_d.rec  = rec_d;
        res_d.exc  = exc_d;
        res_d.irq  = irq_d;
    end

    generate
        if (PIPE) begin : g_pipe
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    res_q <= '0;
                end else begin
                    res_q <= res_d;
                end
            end

            // R1
            a_r1_l3_off_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
                (l3_mode == 2'b00) |=> (eff_mode == 2'b00));
            // R2
            a_r2_no_hyp_delegates: assert property (@(posedge clk) disable iff (!rst_n)
                ((l3_mode != 2'b00) && (!hyp_present || (!sec_ns && !sec_l2en)))
                |=> (eff_mode == 2'b01));
            // R3
            a_r3_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
                ((l3_mode != 2'b00) && hyp_present && (sec_ns || sec_l2en))
                |=> (eff_mode == $past(cfg_mode)));
            // R7
            a_r7_no_event_no_record: assert property (@(posedge clk) disable iff (!rst_n)
                (!evt_valid || l3_divert) |=> !rec_l2);
            // R8
            a_r8_kernel_mask: assert property (@(posedge clk) disable iff (!rst_n)
                !kern_en |=> !exc_req);
        end else begin : g_comb
            assign res_q = res_d;

            // R1
            a_r1_l3_off_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
                (l3_mode == 2'b00) |-> (eff_mode == 2'b00));
            // R2
            a_r2_no_hyp_delegates: assert property (@(posedge clk) disable iff (!rst_n)
                ((l3_mode != 2'b00) && (!hyp_present || (!sec_ns && !sec_l2en)))
                |-> (eff_mode == 2'b01));
            // R3
            a_r3_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
                ((l3_mode != 2'b00) && hyp_present && (sec_ns || sec_l2en))
                |-> (eff_mode == cfg_mode));
            // R7
            a_r7_no_event_no_record: assert property (@(posedge clk) disable iff (!rst_n)
                (!evt_valid || l3_divert) |-> !rec_l2);
            // R8
            a_r8_kernel_mask: assert property (@(posedge clk) disable iff (!rst_n)
                !kern_en |-> !exc_req);
        end
    endgenerate

    assign eff_mode = res_q.mode;
    assign rec_l2   = res_q.rec;
    assign exc_req  = res_q.exc;
    assign irq_l1   = res_q.irq;

    // R4: recording only in the two high modes
    a_r4_record_needs_high_mode: assert property (@(posedge clk) disable iff (!rst_n)
        rec_l2 |-> eff_mode[1]);
    // R9: no exception request while OFF
    a_r9_no_exc_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> (eff_mode != 2'b00));
    // R10: interrupt line only in OFF
    a_r10_irq_only_off: assert property (@(posedge clk) disable iff (!rst_n)
        irq_l1 |-> (eff_mode == 2'b00));
endmodule

// File: tb/sim_pxr_resolver.sv
module sim_pxr_resolver;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_mode = 2'b00;
    logic [1:0] l3_mode = 2'b00;
    logic       l3_divert = 1'b0;
    logic       hyp_present = 1'b0;
    logic       sec_ns = 1'b0;
    logic       sec_l2en = 1'b0;
    logic       owner_l2 = 1'b0;
    logic       evt_valid = 1'b0;
    logic [2:0] evt_class = 3'd0;
    logic       abort_route = 1'b0;
    logic       prot_route = 1'b0;
    logic       gen_trap = 1'b0;
    logic       svc_l2 = 1'b0;
    logic       svc_l1 = 1'b0;
    logic       kern_en = 1'b0;
    logic       pm_bit = 1'b0;
    logic [1:0] eff_mode;
    logic       rec_l2;
    logic       exc_req;
    logic       irq_l1;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pxr_resolver #(.PIPE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .l3_mode(l3_mode),
        .l3_divert(l3_divert), .hyp_present(hyp_present), .sec_ns(sec_ns),
        .sec_l2en(sec_l2en), .owner_l2(owner_l2), .evt_valid(evt_valid),
        .evt_class(evt_class), .abort_route(abort_route), .prot_route(prot_route),
        .gen_trap(gen_trap), .svc_l2(svc_l2), .svc_l1(svc_l1), .kern_en(kern_en),
        .pm_bit(pm_bit), .eff_mode(eff_mode), .rec_l2(rec_l2), .exc_req(exc_req),
        .irq_l1(irq_l1)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [1:0] m_mode(input logic [1:0] c, input logic [1:0] l3,
                                          input logic h, input logic n, input logic e);
        if (l3 == 2'b00) return 2'b00;
        if (!h || (!n && !e)) return 2'b01;
        return c;
    endfunction

    function automatic logic m_rec(input logic [1:0] m, input logic own, input logic v,
                                   input logic [2:0] cl, input logic ab, input logic pr,
                                   input logic dv);
        logic hit;
        if (!v || dv || m < 2) return 1'b0;
        if (m == 2'b11) return 1'b1;
        case (cl)
            3'd1:       hit = own;
            3'd2, 3'd5: hit = 1'b1;
            3'd3:       hit = own || ab;
            3'd4:       hit = own || pr;
            default:    hit = 1'b0;
        endcase
        return hit;
    endfunction

    function automatic logic m_exc(input logic [1:0] m, input logic gt, input logic s2,
                                   input logic ke, input logic pm);
        logic um;
        um = ke && !pm;
        if (m == 2'b00) return 1'b0;
        if (m == 2'b01) return gt && s2 && um;
        return s2 && um;
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R11 reset state: inputs would give irq=1 in OFF mode
        svc_l1 = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11", "eff_mode in reset", int'(eff_mode), 0);
        chk("R11", "irq_l1 in reset", int'(irq_l1), 0);
        chk("R11", "rec/exc in reset", int'({rec_l2, exc_req}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "irq follows svc_l1 in OFF", int'(irq_l1), 1);
        // R11 latency: change must not appear before the next rising edge
        l3_mode = 2'b01;
        #1;
        chk("R11", "irq before edge", int'(irq_l1), 1);
        @(negedge clk);
        chk("R11", "irq after edge", int'(irq_l1), 0);
        chk("R11", "eff_mode after edge", int'(eff_mode), 1);

        // Sweep A: mode resolution
        for (int i = 0; i < 128; i++) begin
            logic [1:0] em;
            string tg;
            {cfg_mode, l3_mode, hyp_present, sec_ns, sec_l2en} = 7'(i);
            evt_valid = 1'b1; evt_class = 3'd0; l3_divert = 1'b0;
            svc_l1 = 1'b1; svc_l2 = 1'b0;
            @(negedge clk);
            em = m_mode(cfg_mode, l3_mode, hyp_present, sec_ns, sec_l2en);
            tg = (l3_mode == 2'b00) ? "R1" :
                 ((!hyp_present || (!sec_ns && !sec_l2en)) ? "R2" : "R3");
            chk(tg, "eff_mode", int'(eff_mode), int'(em));
            chk("R6", "management event record", int'(rec_l2), int'(em == 2'b11));
            chk("R10", "irq_l1", int'(irq_l1), int'(em == 2'b00));
        end

        // Sweep B: recording (effective mode equals cfg_mode)
        l3_mode = 2'b01; hyp_present = 1'b1; sec_ns = 1'b1; sec_l2en = 1'b0;
        svc_l1 = 1'b0;
        for (int i = 0; i < 1024; i++) begin
            string tg;
            {cfg_mode, owner_l2, evt_valid, evt_class, l3_divert, abort_route, prot_route} = 10'(i);
            @(negedge clk);
            if (!evt_valid || l3_divert) tg = "R7";
            else if (cfg_mode < 2) tg = "R4";
            else if (cfg_mode == 2'b10) tg = "R5";
            else tg = "R6";
            chk(tg, "rec_l2", int'(rec_l2),
                int'(m_rec(cfg_mode, owner_l2, evt_valid, evt_class, abort_route, prot_route, l3_divert)));
        end

        // Sweep C: exception and interrupt
        evt_valid = 1'b0; l3_divert = 1'b0;
        for (int i = 0; i < 256; i++) begin
            logic [1:0] em;
            {l3_mode[0], cfg_mode, gen_trap, svc_l2, svc_l1, kern_en, pm_bit} = 8'(i);
            l3_mode[1] = 1'b0;
            @(negedge clk);
            em = (l3_mode == 2'b00) ? 2'b00 : cfg_mode;
            chk(kern_en ? "R9" : "R8", "exc_req", int'(exc_req),
                int'(m_exc(em, gen_trap, svc_l2, kern_en, pm_bit)));
            chk("R10", "irq_l1", int'(irq_l1), int'((em == 2'b00) && svc_l1));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule